// File: doc/BRIEF.md
# Byte-Wide USB FIFO Bridge Controller

This controller connects on-chip logic to an external USB device that exposes an asynchronous, byte-wide FIFO port. Toward the device it drives active-low read and write strobes. It watches three active-low status lines: receive data present, transmit space free, and device configured. It exchanges bytes over a shared data bus. The bus is split into an input, an output and a drive enable for the pad cell. Every status and data input is registered once before any decision uses it.

Toward the user logic there are two valid/ready byte streams, each buffered by a small internal FIFO. The transmit stream accepts a byte on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` falls when the transmit FIFO is full. The receive stream presents a byte while `rx_valid` is high. That byte and `rx_valid` stay unchanged until `rx_ready` is seen high on a clock edge. The controller alternates between a read-idle state and a write-idle state. Each state tests its own start condition and otherwise passes to the other state on the next clock. Strobe widths and the read-to-write bus turnaround are counted in clock cycles.

Top module: `usbfifo_bridge`

## Requirements
- R1: During and after reset, `ext_rd_n` and `ext_wr_n` are 1, `ext_data_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: A read strobe starts only when the registered receive-present and configured inputs were both low and the receive FIFO has space. `ext_rd_n` is then low for exactly RD_LOW_CYC cycles.
- R3: The bus value sampled in the last low cycle of the read strobe is delivered on `rx_data`. Bytes arrive in the order the device supplied them.
- R4: A write starts only when the transmit FIFO holds a byte and the registered transmit-free input was low. `ext_wr_n` is low for exactly WR_LOW_CYC cycles. Bytes leave in the order they were accepted.
- R5: `ext_data_oe` is 1 only within a write cycle. It rises one cycle before `ext_wr_n` falls and stays 1 until one cycle after `ext_wr_n` rises. `ext_rd_n` and `ext_wr_n` are never low together.
- R6: After `ext_rd_n` rises, at least TURN_CYC cycles pass with `ext_data_oe` low before the drivers are enabled again.
- R7: When both directions have work pending, reads and writes take turns, one each.
- R8: With the receive FIFO full, no read strobe is issued. Bytes waiting in the device are fetched later without loss.
- R9: `rx_data` and `rx_valid` hold steady while `rx_ready` is 0. `tx_ready` is 0 while the transmit FIFO holds DEPTH bytes.
- R10: While the configured input is high, no read is started, even when receive data is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_data_i | input | 8 | Data bus value from the pad |
| ext_data_o | output | 8 | Data bus value to the pad |
| ext_data_oe | output | 1 | Pad drive enable, 1 only during writes |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rxf_n | input | 1 | Device holds a byte for reading, active low |
| ext_txe_n | input | 1 | Device can accept a byte, active low |
| ext_pwren_n | input | 1 | Device configured, active low |
| tx_data | input | 8 | Byte to send to the device |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit FIFO can accept a byte |
| rx_data | output | 8 | Byte read from the device |
| rx_valid | output | 1 | `rx_data` is valid |
| rx_ready | input | 1 | User accepts `rx_data` |

## Verification
The bench models the device in two parts. The first is a queue of host bytes. It raises receive-present while the strobe is low and steps to the next byte when the strobe rises. The second is a write side that blocks transmit-free for a few cycles after each write strobe.

A vector table sends paired bytes in both directions, one pair at a time. This separates a lost or reordered byte from a strobe of the wrong width.

Directed cases do the following:
- hold the configured line high, to check that reads are gated;
- hold transmit-free high, to check that writes are gated and that the transmit FIFO fills;
- stall the receive stream, to show full back-pressure without byte loss;
- release both directions at once, to show the reads and writes taking turns.

// File: rtl/usbfifo_pkg.sv
package usbfifo_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE_RD,
    ST_IDLE_WR,
    ST_RD_STB,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_STB,
    ST_WR_HOLD
  } bridge_st_e;
endpackage

// File: rtl/usbfifo_sfifo.sv
module usbfifo_sfifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  assign dout  = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/usbfifo_ctrl.sv
module usbfifo_ctrl
  import usbfifo_pkg::*;
#(
  parameter int RD_LOW_CYC = 4,
  parameter int WR_LOW_CYC = 4,
  parameter int TURN_CYC   = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t pin_din,
  input  logic  pin_rxf_n,
  input  logic  pin_txe_n,
  input  logic  pin_pwren_n,
  input  logic  rx_full,
  input  logic  tx_empty,
  input  byte_t tx_byte,
  output logic  rx_push,
  output byte_t rx_byte,
  output logic  tx_pop,
  output byte_t pin_dout,
  output logic  pin_oe,
  output logic  pin_rd_n,
  output logic  pin_wr_n
);
  localparam int CMAX0 = (RD_LOW_CYC > WR_LOW_CYC) ? RD_LOW_CYC : WR_LOW_CYC;
  localparam int CMAX  = (CMAX0 > TURN_CYC) ? CMAX0 : TURN_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] TN_LAST = CNT_W'(TURN_CYC - 1);

  bridge_st_e       st;
  logic [CNT_W-1:0] cnt;
  byte_t            din_q;
  logic             rxf_q, txe_q, pwr_q;
  logic             rd_go, wr_go;

  // one register stage on every device input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      rxf_q <= 1'b1;
      txe_q <= 1'b1;
      pwr_q <= 1'b1;
    end else begin
      din_q <= pin_din;
      rxf_q <= pin_rxf_n;
      txe_q <= pin_txe_n;
      pwr_q <= pin_pwren_n;
    end
  end

  assign rd_go   = (st == ST_IDLE_RD) && !rxf_q && !pwr_q && !rx_full;
  assign wr_go   = (st == ST_IDLE_WR) && !tx_empty && !txe_q;
  assign tx_pop  = wr_go;
  assign rx_push = (st == ST_RD_STB) && (cnt == RD_LAST);
  assign rx_byte = din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE_RD;
      cnt      <= '0;
      pin_rd_n <= 1'b1;
      pin_wr_n <= 1'b1;
      pin_oe   <= 1'b0;
      pin_dout <= '0;
    end else begin
      unique case (st)
        ST_IDLE_RD: begin
          if (rd_go) begin
            pin_rd_n <= 1'b0;
            cnt      <= '0;
            st       <= ST_RD_STB;
          end else begin
            st <= ST_IDLE_WR;
          end
        end
        ST_RD_STB: begin
          if (cnt == RD_LAST) begin
            pin_rd_n <= 1'b1;
            cnt      <= '0;
            st       <= ST_RD_TURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD_TURN: begin
          if (cnt == TN_LAST) st <= ST_IDLE_WR;
          else                cnt <= cnt + 1'b1;
        end
        ST_IDLE_WR: begin
          if (wr_go) begin
            pin_dout <= tx_byte;
            pin_oe   <= 1'b1;
            st       <= ST_WR_SETUP;
          end else begin
            st <= ST_IDLE_RD;
          end
        end
        ST_WR_SETUP: begin
          pin_wr_n <= 1'b0;
          cnt      <= '0;
          st       <= ST_WR_STB;
        end
        ST_WR_STB: begin
          if (cnt == WR_LAST) begin
            pin_wr_n <= 1'b1;
            st       <= ST_WR_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WR_HOLD: begin
          pin_oe <= 1'b0;
          st     <= ST_IDLE_RD;
        end
        default: st <= ST_IDLE_RD;
      endcase
    end
  end
endmodule

// File: rtl/usbfifo_bridge.sv
module usbfifo_bridge
  import usbfifo_pkg::*;
#(
  parameter int RD_LOW_CYC = 4,
  parameter int WR_LOW_CYC = 4,
  parameter int TURN_CYC   = 2,
  parameter int DEPTH      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ext_data_i,
  output logic [7:0] ext_data_o,
  output logic       ext_data_oe,
  output logic       ext_rd_n,
  output logic       ext_wr_n,
  input  logic       ext_rxf_n,
  input  logic       ext_txe_n,
  input  logic       ext_pwren_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready
);
  logic  rx_push, rx_full, rx_empty;
  logic  tx_pop, tx_full, tx_empty;
  byte_t rx_byte, tx_byte;

  usbfifo_sfifo #(.W(8), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_byte),
    .pop(rx_valid && rx_ready), .dout(rx_data),
    .full(rx_full), .empty(rx_empty)
  );

  usbfifo_sfifo #(.W(8), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid && tx_ready), .din(tx_data),
    .pop(tx_pop), .dout(tx_byte),
    .full(tx_full), .empty(tx_empty)
  );

  assign rx_valid = !rx_empty;
  assign tx_ready = !tx_full;

  usbfifo_ctrl #(
    .RD_LOW_CYC(RD_LOW_CYC), .WR_LOW_CYC(WR_LOW_CYC), .TURN_CYC(TURN_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .pin_din(ext_data_i), .pin_rxf_n(ext_rxf_n),
    .pin_txe_n(ext_txe_n), .pin_pwren_n(ext_pwren_n),
    .rx_full(rx_full), .tx_empty(tx_empty), .tx_byte(tx_byte),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
    .pin_dout(ext_data_o), .pin_oe(ext_data_oe),
    .pin_rd_n(ext_rd_n), .pin_wr_n(ext_wr_n)
  );
endmodule

// File: rtl/usbfifo_bridge_chk.sv
module usbfifo_bridge_chk #(
  parameter int RD_LOW_CYC = 4,
  parameter int WR_LOW_CYC = 4,
  parameter int TURN_CYC   = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_data_oe,
  input logic       ext_rd_n,
  input logic       ext_wr_n,
  input logic       ext_rxf_n,
  input logic       ext_txe_n,
  input logic       ext_pwren_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready
);
  logic [7:0] rd_run, wr_run, since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run   <= '0;
      wr_run   <= '0;
      since_rd <= 8'hFF;
    end else begin
      rd_run   <= ext_rd_n ? 8'd0 : ((rd_run == 8'hFF) ? rd_run : rd_run + 8'd1);
      wr_run   <= ext_wr_n ? 8'd0 : ((wr_run == 8'hFF) ? wr_run : wr_run + 8'd1);
      since_rd <= !ext_rd_n ? 8'd0 : ((since_rd == 8'hFF) ? since_rd : since_rd + 8'd1);
    end
  end

  a_r2_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd_n) |-> (rd_run == 8'(RD_LOW_CYC)));

  a_r2_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_rd_n) |-> (!$past(ext_rxf_n, 2) && !$past(ext_pwren_n, 2)));

  a_r4_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_wr_n) |-> (wr_run == 8'(WR_LOW_CYC)));

  a_r4_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_data_oe) |-> !$past(ext_txe_n, 2));

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  a_r5_oe_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> ext_rd_n);

  a_r5_wr_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> ext_data_oe);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_data_oe) |-> (since_rd >= 8'(TURN_CYC)));

  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind usbfifo_bridge usbfifo_bridge_chk #(
  .RD_LOW_CYC(RD_LOW_CYC), .WR_LOW_CYC(WR_LOW_CYC), .TURN_CYC(TURN_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_data_oe(ext_data_oe),
  .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rxf_n(ext_rxf_n),
  .ext_txe_n(ext_txe_n), .ext_pwren_n(ext_pwren_n),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/usbfifo_bridge_tb_top.sv
`timescale 1ns/1ps
module usbfifo_bridge_tb_top;
  localparam int RDL = 4;
  localparam int WRL = 4;
  localparam int TRN = 2;
  localparam int DEP = 4;
  localparam int TXE_BLOCK = 8;
  localparam int NV = 6;
  // upper byte: device -> user, lower byte: user -> device
  localparam logic [15:0] VEC [NV] = '{16'hA55A, 16'h0000, 16'hFFFF,
                                       16'h3C81, 16'h7E01, 16'h12ED};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] ext_data_i, ext_data_o, tx_data, rx_data;
  logic ext_data_oe, ext_rd_n, ext_wr_n, ext_rxf_n, ext_txe_n;
  logic ext_pwren_n = 1'b0;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;

  usbfifo_bridge #(.RD_LOW_CYC(RDL), .WR_LOW_CYC(WRL), .TURN_CYC(TRN), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_data_i(ext_data_i), .ext_data_o(ext_data_o),
    .ext_data_oe(ext_data_oe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_rxf_n(ext_rxf_n), .ext_txe_n(ext_txe_n), .ext_pwren_n(ext_pwren_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // device model and monitors, all on the falling edge
  logic [7:0] host_q [64];
  logic [7:0] dev_q  [64];
  int hwp = 0, hrp = 0, dcnt = 0, blk = 0;
  logic txe_force = 1'b0;
  int ops [64];
  int nops = 0, nrd = 0, nwr = 0;
  int rd_run = 0, wr_run = 0, since_rd = 1000, min_gap = 1000;
  int rd_bad = 0, wr_bad = 0, excl_bad = 0, oe_bad = 0, setup_bad = 0;
  logic p_rd = 1'b1, p_wr = 1'b1, p_oe = 1'b0;

  assign ext_rxf_n  = (hwp == hrp) || !ext_rd_n;
  assign ext_data_i = !ext_rd_n ? host_q[hrp[5:0]] : 8'h00;
  assign ext_txe_n  = txe_force || (blk != 0);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ext_rd_n) rd_run <= rd_run + 1;
      if (!ext_wr_n) wr_run <= wr_run + 1;
      since_rd <= !ext_rd_n ? 0 : since_rd + 1;
      if (blk != 0) blk <= blk - 1;
      if (p_rd && !ext_rd_n) begin ops[nops[5:0]] <= 0; nops <= nops + 1; nrd <= nrd + 1; end
      if (!p_rd && ext_rd_n) begin
        hrp <= hrp + 1;
        if (rd_run != RDL) rd_bad <= rd_bad + 1;
        rd_run <= 0;
      end
      if (p_wr && !ext_wr_n) begin
        ops[nops[5:0]] <= 1; nops <= nops + 1; nwr <= nwr + 1;
        blk <= TXE_BLOCK;
        if (p_oe == 1'b0) setup_bad <= setup_bad + 1;
      end
      if (!p_wr && ext_wr_n) begin
        dev_q[dcnt[5:0]] <= ext_data_o; dcnt <= dcnt + 1;
        if (!ext_data_oe) oe_bad <= oe_bad + 1;
        if (wr_run != WRL) wr_bad <= wr_bad + 1;
        wr_run <= 0;
      end
      if (!ext_rd_n && !ext_wr_n) excl_bad <= excl_bad + 1;
      if (ext_data_oe && !ext_rd_n) oe_bad <= oe_bad + 1;
      if (!p_oe && ext_data_oe && since_rd < min_gap) min_gap <= since_rd;
      p_rd <= ext_rd_n; p_wr <= ext_wr_n; p_oe <= ext_data_oe;
    end
  end

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b, output bit ok);
    int n;
    n = 0; ok = 1'b0; b = 8'h00;
    while (!rx_valid && n < 2000) begin @(negedge clk); n++; end
    if (rx_valid) begin
      b = rx_data; ok = 1'b1; rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  task automatic wait_dev(input int n);
    int k;
    k = 0;
    while (dcnt < n && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b, hold_b;
    bit ok;
    int r0, w0, alt_bad, base;
    tx_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ext_rd_n == 1'b1, "R1 rd_n", ext_rd_n, 1);
    chk(ext_wr_n == 1'b1, "R1 wr_n", ext_wr_n, 1);
    chk(ext_data_oe == 1'b0, "R1 oe", ext_data_oe, 0);
    chk(rx_valid == 1'b0 && tx_ready == 1'b1, "R1 stream flags",
        {rx_valid, tx_ready}, 2'b01);
    rst_n = 1'b1;
    idle(5);
    chk(ext_rd_n && ext_wr_n && !ext_data_oe, "R1 idle after reset",
        {ext_rd_n, ext_wr_n, ext_data_oe}, 3'b110);

    // table walk: one byte each way per vector (R3, R4)
    for (int i = 0; i < NV; i++) begin
      host_q[hwp[5:0]] = VEC[i][15:8];
      hwp = hwp + 1;
      push_tx(VEC[i][7:0]);
      pop_rx(b, ok);
      chk(ok && b == VEC[i][15:8], "R3 rx byte", b, VEC[i][15:8]);
      wait_dev(i + 1);
      chk(dcnt == i + 1 && dev_q[i] == VEC[i][7:0], "R4 tx byte", dev_q[i], VEC[i][7:0]);
    end
    idle(20);
    chk(rd_bad == 0, "R2 rd strobe width", rd_bad, 0);
    chk(wr_bad == 0, "R4 wr strobe width", wr_bad, 0);
    chk(setup_bad == 0 && oe_bad == 0, "R5 oe around wr", setup_bad + oe_bad, 0);
    chk(excl_bad == 0, "R5 strobes exclusive", excl_bad, 0);
    chk(min_gap >= TRN, "R6 turnaround gap", min_gap, TRN);

    // R10: not configured blocks reads
    ext_pwren_n = 1'b1;
    r0 = nrd;
    host_q[hwp[5:0]] = 8'hC3; hwp = hwp + 1;
    idle(60);
    chk(nrd == r0 && !rx_valid, "R10 no read unconfigured", nrd - r0, 0);
    ext_pwren_n = 1'b0;
    pop_rx(b, ok);
    chk(ok && b == 8'hC3, "R10 read after configure", b, 8'hC3);

    // R4/R9: transmit-free held high, tx fifo fills
    txe_force = 1'b1;
    w0 = nwr;
    for (int i = 0; i < DEP; i++) push_tx(8'h50 + 8'(i));
    idle(2);
    chk(tx_ready == 1'b0, "R9 tx_ready low when full", tx_ready, 0);
    idle(50);
    chk(nwr == w0, "R4 no write while blocked", nwr - w0, 0);
    base = dcnt;
    txe_force = 1'b0;
    wait_dev(base + DEP);
    for (int i = 0; i < DEP; i++)
      chk(dev_q[base + i] == 8'h50 + 8'(i), "R4 order after unblock",
          dev_q[base + i], 8'h50 + 8'(i));

    // R8/R9: rx stalled, fifo full, device keeps extra bytes
    r0 = nrd;
    for (int i = 0; i < DEP + 2; i++) begin
      host_q[hwp[5:0]] = 8'h90 + 8'(i); hwp = hwp + 1;
    end
    idle(150);
    chk(nrd - r0 == DEP, "R8 reads stop at full", nrd - r0, DEP);
    hold_b = rx_data;
    idle(10);
    chk(rx_valid && rx_data == hold_b, "R9 rx held under stall", rx_data, hold_b);
    for (int i = 0; i < DEP + 2; i++) begin
      pop_rx(b, ok);
      chk(ok && b == 8'h90 + 8'(i), "R8 no byte lost", b, 8'h90 + 8'(i));
    end

    // R7: both directions pending, released together
    ext_pwren_n = 1'b1;
    txe_force = 1'b1;
    idle(20);
    base = nops;
    for (int i = 0; i < 3; i++) begin
      host_q[hwp[5:0]] = 8'hE0 + 8'(i); hwp = hwp + 1;
      push_tx(8'h20 + 8'(i));
    end
    idle(4);
    ext_pwren_n = 1'b0;
    txe_force = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pop_rx(b, ok);
      chk(ok && b == 8'hE0 + 8'(i), "R7 rx while alternating", b, 8'hE0 + 8'(i));
    end
    idle(80);
    chk(nops - base == 6, "R7 op count", nops - base, 6);
    alt_bad = 0;
    for (int i = base + 1; i < base + 6; i++)
      if (ops[i[5:0]] == ops[(i - 1) & 63]) alt_bad++;
    chk(alt_bad == 0, "R7 reads and writes alternate", alt_bad, 0);
    chk(rd_bad == 0 && wr_bad == 0 && excl_bad == 0 && oe_bad == 0,
        "R5 strobe rules overall", rd_bad + wr_bad + excl_bad + oe_bad, 0);
    chk(min_gap >= TRN, "R6 turnaround overall", min_gap, TRN);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule